// File: doc/BRIEF.md
# Streaming RMS Measurement Engine

The engine takes a stream of unipolar converter samples, each tagged with a channel number. It measures the root-mean-square level of one chosen channel over a block of N samples. A start pulse captures the configuration: the target channel, a block-length code and a mid-scale removal enable. The same pulse clears any earlier measurement and opens a new block. Each sample from the chosen channel is squared and added to a wide accumulator. Mid-scale is subtracted from the sample first when removal is enabled. After the N-th such sample, the sum is divided by N with a right shift. A 16-bit integer square root is then formed one result bit per clock.

The engine still waits for a fixed tail of 40 further samples from the chosen channel before it raises a sticky done flag and publishes the 16-bit result. One result LSB is one input LSB, that is full scale divided by 2^16. An alert output repeats the done flag when its mask input is set. The engine is single-shot: after completion it holds its result until the next start pulse.

Top module: `rms_engine`

## Requirements
- R1: After reset, `rms_out` is 0, and `done` and `alert` are low.
- R2: A sample counts only when `smp_valid` is 1 and `smp_chan` equals the channel captured at start. Any other sample leaves both the block and the tail unchanged.
- R3: With mid-scale removal off, each sample s contributes s*s. The result is floor(sqrt(floor(sum / N))), with N = 2^(MIN_LOG2 + STEP*code), where code is the captured `cfg_len_code`.
- R4: With mid-scale removal on, each sample contributes (s - 2^(DATA_W-1))^2, with the difference taken as signed, so that sample 0 contributes 2^30 and sample 32768 contributes 0. The result follows the same formula as R3.
- R5: `done` stays low until the 40th counting sample after the N-th block sample. It goes high on the clock edge that takes that 40th tail sample, and `rms_out` carries the new result from that same edge.
- R6: Once high, `done` stays high and `rms_out` stays unchanged until the next `start`, whatever samples arrive.
- R7: `start` clears `done`, the accumulator and both counters on its own edge. It discards any measurement in progress. A counting sample on the `start` cycle is the first sample of the new block.
- R8: `alert` is high exactly when `done` is high and `alert_en` is 1. `alert_en` is not captured, so it acts immediately.
- R9: `cfg_chan`, `cfg_len_code` and `cfg_dc_sub` are sampled only on the `start` cycle. Later changes have no effect on the measurement in progress.
- R10: Before the first `start`, samples are ignored. `done` stays low and `rms_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CH_W | Channel tag of the sample |
| smp_data | input | DATA_W | Unsigned sample word |
| cfg_chan | input | CH_W | Channel to measure, captured at start |
| cfg_len_code | input | LEN_W | Block length code, N = 2^(MIN_LOG2+STEP*code) |
| cfg_dc_sub | input | 1 | Mid-scale removal enable, captured at start |
| start | input | 1 | One-cycle pulse that begins a fresh measurement |
| alert_en | input | 1 | Routes done to alert |
| rms_out | output | DATA_W | RMS result, valid while done is high |
| done | output | 1 | Sticky completion flag |
| alert | output | 1 | Completion alert request |

## Verification
The bench uses constant full-scale samples with removal off. These must give a result of exactly 65535, which shows whether the accumulator and the shift lose a top bit. Constant zeros with removal on give 32768, and constant mid-scale with removal on gives 0; together they pin the sign handling of the subtraction.

Random full-range words, and words clustered around mid-scale, are also applied. They are mixed with foreign-channel samples, strobes held low and configuration inputs changed after start. These runs separate correct channel filtering and start-time capture from accidental ones. They also compare the root's floor rounding against an independent binary search.

Sample-count boundaries are checked at the last block sample and at the 39th and 40th tail samples. A restart is issued in the middle of a block, and samples arrive before the first start. These cases expose off-by-one counting and stale state.

// File: rtl/rms_pkg.sv
`timescale 1ns/1ps
package rms_pkg;
  // measurement phase of the engine
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // no start seen since reset
    PH_BLOCK = 2'd1,  // accumulating the N-sample block
    PH_TAIL  = 2'd2,  // counting the settling tail
    PH_HOLD  = 2'd3   // result published, waiting for a new start
  } phase_t;
endpackage

// File: rtl/rms_square.sv
`timescale 1ns/1ps
module rms_square #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   smp,
  input  logic                dc_sub,
  output logic [2*DATA_W-1:0] sq
);
  localparam int SQ_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] HALF = DATA_W'(1) << (DATA_W - 1);

  // magnitude of the (optionally mid-scale removed) sample, then its square
  function automatic logic [SQ_W-1:0] square_of(input logic [DATA_W-1:0] s,
                                                 input logic dc);
    logic [DATA_W-1:0] mag;
    logic [SQ_W-1:0]   wide;
    if (!dc)            mag = s;
    else if (s >= HALF) mag = s - HALF;
    else                mag = HALF - s;
    wide = {{DATA_W{1'b0}}, mag};
    return wide * wide;
  endfunction

  always_comb sq = square_of(smp, dc_sub);
endmodule

// File: rtl/rms_accum.sv
`timescale 1ns/1ps
module rms_accum
  import rms_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 2,
  parameter int MIN_LOG2 = 10,
  parameter int STEP     = 2,
  parameter int TAIL_N   = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                qual,
  input  logic [2*DATA_W-1:0] sq,
  input  logic [LEN_W-1:0]    len_code,
  output phase_t              phase,
  output logic                blk_last,
  output logic                tail_last,
  output logic                mean_go,
  output logic [2*DATA_W-1:0] mean
);
  localparam int SQ_W     = 2 * DATA_W;
  localparam int MAX_LOG2 = MIN_LOG2 + STEP * ((1 << LEN_W) - 1);
  localparam int ACC_W    = SQ_W + MAX_LOG2;
  localparam int CNT_W    = MAX_LOG2 + 1;
  localparam int TAIL_W   = $clog2(TAIL_N + 1);
  localparam int SH_W     = $clog2(MAX_LOG2 + 1);

  phase_t            phase_q;
  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TAIL_W-1:0] tail_q;
  logic              mean_go_q;
  logic [SQ_W-1:0]   mean_q;

  logic [SH_W-1:0]   shift_amt;
  logic [CNT_W-1:0]  blk_target_m1;
  logic [ACC_W-1:0]  acc_sum;
  logic [ACC_W-1:0]  mean_full;

  always_comb begin
    shift_amt     = SH_W'(MIN_LOG2 + STEP * int'(len_code));
    blk_target_m1 = (CNT_W'(1) << shift_amt) - CNT_W'(1);
    acc_sum       = acc_q + ACC_W'(sq);
    mean_full     = acc_sum >> shift_amt;
    blk_last      = !start && (phase_q == PH_BLOCK) && qual && (cnt_q == blk_target_m1);
    tail_last     = !start && (phase_q == PH_TAIL) && qual && (tail_q == TAIL_W'(TAIL_N - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      acc_q     <= '0;
      cnt_q     <= '0;
      tail_q    <= '0;
      mean_go_q <= 1'b0;
      mean_q    <= '0;
    end else begin
      mean_go_q <= blk_last;
      if (start) begin
        phase_q <= PH_BLOCK;
        acc_q   <= qual ? ACC_W'(sq) : '0;
        cnt_q   <= qual ? CNT_W'(1) : '0;
        tail_q  <= '0;
      end else begin
        case (phase_q)
          PH_BLOCK: if (qual) begin
            acc_q <= acc_sum;
            cnt_q <= cnt_q + CNT_W'(1);
            if (blk_last) begin
              phase_q <= PH_TAIL;
              mean_q  <= mean_full[SQ_W-1:0];
            end
          end
          PH_TAIL: if (qual) begin
            tail_q <= tail_q + TAIL_W'(1);
            if (tail_last) phase_q <= PH_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign phase   = phase_q;
  assign mean_go = mean_go_q;
  assign mean    = mean_q;
endmodule

// File: rtl/rms_isqrt.sv
`timescale 1ns/1ps
module rms_isqrt #(
  parameter int ROOT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [2*ROOT_W-1:0] rad,
  output logic                busy,
  output logic [ROOT_W-1:0]   root
);
  localparam int RAD_W = 2 * ROOT_W;
  localparam int REM_W = ROOT_W + 2;
  localparam int CUR_W = REM_W + 2;
  localparam int IT_W  = $clog2(ROOT_W + 1);

  // one digit of the shift-and-subtract recurrence: returns {remainder, root}
  function automatic logic [REM_W+ROOT_W-1:0] digit_step(input logic [REM_W-1:0]  rem,
                                                          input logic [ROOT_W-1:0] rt,
                                                          input logic [1:0]        pair);
    logic [CUR_W-1:0] cur;
    logic [CUR_W-1:0] trial;
    logic [CUR_W-1:0] diff;
    cur   = {rem, pair};
    trial = CUR_W'({rt, 2'b01});
    diff  = cur - trial;
    if (cur >= trial) return {diff[REM_W-1:0], rt[ROOT_W-2:0], 1'b1};
    else              return {cur[REM_W-1:0],  rt[ROOT_W-2:0], 1'b0};
  endfunction

  logic [RAD_W-1:0]        rad_q;
  logic [REM_W-1:0]        rem_q;
  logic [ROOT_W-1:0]       root_q;
  logic [IT_W-1:0]         it_q;
  logic [REM_W+ROOT_W-1:0] nxt;

  always_comb nxt = digit_step(rem_q, root_q, rad_q[RAD_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      it_q   <= '0;
    end else if (go) begin
      rad_q  <= rad;
      rem_q  <= '0;
      root_q <= '0;
      it_q   <= IT_W'(ROOT_W);
    end else if (it_q != '0) begin
      rem_q  <= nxt[REM_W+ROOT_W-1:ROOT_W];
      root_q <= nxt[ROOT_W-1:0];
      rad_q  <= rad_q << 2;
      it_q   <= it_q - IT_W'(1);
    end
  end

  assign busy = (it_q != '0);
  assign root = root_q;
endmodule

// File: rtl/rms_engine.sv
`timescale 1ns/1ps
module rms_engine
  import rms_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CH_W     = 3,
  parameter int LEN_W    = 2,
  parameter int MIN_LOG2 = 10,
  parameter int STEP     = 2,
  parameter int TAIL_N   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [LEN_W-1:0]  cfg_len_code,
  input  logic              cfg_dc_sub,
  input  logic              start,
  input  logic              alert_en,
  output logic [DATA_W-1:0] rms_out,
  output logic              done,
  output logic              alert
);
  localparam int SQ_W = 2 * DATA_W;

  // captured configuration
  logic [CH_W-1:0]  chan_q;
  logic [LEN_W-1:0] code_q;
  logic             dc_q;
  // configuration in force this cycle (the start cycle uses the live inputs)
  logic [CH_W-1:0]  eff_chan;
  logic [LEN_W-1:0] eff_code;
  logic             eff_dc;

  // named internal events, observed by the checker
  logic              qual_smp;
  logic [SQ_W-1:0]   sq_term;
  phase_t            phase;
  logic              blk_last;
  logic              tail_last;
  logic              mean_go;
  logic [SQ_W-1:0]   mean;
  logic              sqrt_busy;
  logic [DATA_W-1:0] sqrt_root;

  logic              done_q;
  logic [DATA_W-1:0] rms_q;

  always_comb begin
    eff_chan = start ? cfg_chan     : chan_q;
    eff_code = start ? cfg_len_code : code_q;
    eff_dc   = start ? cfg_dc_sub   : dc_q;
    qual_smp = smp_valid && (smp_chan == eff_chan) && (start || phase != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      code_q <= '0;
      dc_q   <= 1'b0;
    end else if (start) begin
      chan_q <= cfg_chan;
      code_q <= cfg_len_code;
      dc_q   <= cfg_dc_sub;
    end
  end

  rms_square #(.DATA_W(DATA_W)) u_square (
    .smp    (smp_data),
    .dc_sub (eff_dc),
    .sq     (sq_term)
  );

  rms_accum #(
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W),
    .MIN_LOG2(MIN_LOG2),
    .STEP    (STEP),
    .TAIL_N  (TAIL_N)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .qual     (qual_smp),
    .sq       (sq_term),
    .len_code (eff_code),
    .phase    (phase),
    .blk_last (blk_last),
    .tail_last(tail_last),
    .mean_go  (mean_go),
    .mean     (mean)
  );

  rms_isqrt #(.ROOT_W(DATA_W)) u_isqrt (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (mean_go),
    .rad  (mean),
    .busy (sqrt_busy),
    .root (sqrt_root)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rms_q  <= '0;
    end else if (start) begin
      done_q <= 1'b0;
    end else if (tail_last) begin
      done_q <= 1'b1;
      rms_q  <= sqrt_root;
    end
  end

  assign done    = done_q;
  assign rms_out = rms_q;
  assign alert   = done_q & alert_en;
endmodule

// File: rtl/rms_engine_chk.sv
`timescale 1ns/1ps
module rms_engine_chk
  import rms_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              alert,
  input logic [DATA_W-1:0] rms_out,
  input phase_t            phase,
  input logic              blk_last,
  input logic              tail_last,
  input logic              sqrt_busy
);
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(rms_out));

  assert_done_after_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tail_last));

  assert_block_to_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last |=> (phase == PH_TAIL));

  assert_root_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tail_last |-> !sqrt_busy);

  assert_alert_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> done);

  assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !done);
endmodule

bind rms_engine rms_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .alert    (alert),
  .rms_out  (rms_out),
  .phase    (phase),
  .blk_last (blk_last),
  .tail_last(tail_last),
  .sqrt_busy(sqrt_busy)
);

// File: tb/test_rms_engine.sv
`timescale 1ns/1ps
module test_rms_engine;
  localparam int DW = 16, CW = 3, LW = 2, MINL = 2, STP = 2, TAILN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [CW-1:0] smp_chan = '0;
  logic [DW-1:0] smp_data = '0;
  logic [CW-1:0] cfg_chan = '0;
  logic [LW-1:0] cfg_len_code = '0;
  logic cfg_dc_sub = 1'b0;
  logic start = 1'b0;
  logic alert_en = 1'b0;
  logic [DW-1:0] rms_out;
  logic done, alert;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rms_engine #(.DATA_W(DW), .CH_W(CW), .LEN_W(LW), .MIN_LOG2(MINL), .STEP(STP), .TAIL_N(TAILN))
    i_rms_engine (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
      .cfg_chan(cfg_chan), .cfg_len_code(cfg_len_code), .cfg_dc_sub(cfg_dc_sub), .start(start),
      .alert_en(alert_en), .rms_out(rms_out), .done(done), .alert(alert));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_term(input longint s, input bit dc);
    longint d;
    d = dc ? s - 32768 : s;
    return d * d;
  endfunction

  // floor square root by binary search
  function automatic longint exp_root(input longint m);
    longint lo, hi, mid;
    lo = 0; hi = 65535;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= m) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic logic [DW-1:0] gen(input int pat);
    case (pat)
      1: return 16'hFFFF;
      2: return 16'h0000;
      3: return 16'h8000;
      4: return 16'(32768 + $urandom_range(0, 600) - 300);
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [CW-1:0] other(input logic [CW-1:0] ch);
    return CW'(int'(ch) + 1 + $urandom_range(0, 6));
  endfunction

  // drive one cycle at a falling edge; return at the next falling edge
  task automatic cyc(input bit v, input logic [CW-1:0] ch, input logic [DW-1:0] d, input bit st);
    smp_valid = v; smp_chan = ch; smp_data = d; start = st;
    @(negedge clk);
    smp_valid = 1'b0; start = 1'b0;
  endtask

  // noise cycle that must not count for channel ch
  task automatic noise(input logic [CW-1:0] ch);
    case ($urandom_range(0, 2))
      0: cyc(1'b0, ch, 16'hFFFF, 1'b0);
      1: cyc(1'b1, other(ch), 16'hFFFF, 1'b0);
      default: cyc(1'b0, ch, 16'h1234, 1'b0);
    endcase
  endtask

  task automatic measure(input int code, input logic [CW-1:0] ch, input bit dc, input bit aen,
                         input int pat, input bit first_on_start, input longint forced_exp);
    longint n, sum, expv;
    int got;
    logic [DW-1:0] s;
    logic [DW-1:0] held;
    string rq;
    n = longint'(1) << (MINL + STP * code);
    sum = 0; got = 0;
    rq = dc ? "R4 R2 R9" : "R3 R2 R9";
    cfg_chan = ch; cfg_len_code = LW'(code); cfg_dc_sub = dc; alert_en = aen;
    if (first_on_start) begin
      s = gen(pat); sum += exp_term(longint'(s), dc); got = 1;
      cyc(1'b1, ch, s, 1'b1);
    end else begin
      cyc(1'b1, other(ch), 16'hFFFF, 1'b1);
    end
    check(done == 1'b0, "R7 done cleared by start", longint'(done), 0);
    // scramble live configuration: it must have no effect (R9)
    cfg_chan = other(ch); cfg_dc_sub = ~dc; cfg_len_code = LW'($urandom_range(0, 3));
    while (got < n) begin
      if ($urandom_range(0, 3) == 0) noise(ch);
      s = gen(pat); sum += exp_term(longint'(s), dc); got++;
      cyc(1'b1, ch, s, 1'b0);
    end
    expv = (forced_exp >= 0) ? forced_exp : exp_root(sum / n);
    for (int t = 0; t < TAILN; t++) begin
      if ($urandom_range(0, 3) == 0) noise(ch);
      if (t == TAILN - 1)
        check(done == 1'b0, "R5 done low before final tail sample", longint'(done), 0);
      cyc(1'b1, ch, gen(0), 1'b0);
    end
    check(done == 1'b1, "R5 done after 40 tail samples", longint'(done), 1);
    check(rms_out == DW'(expv), rq, longint'(rms_out), expv);
    check(alert == aen, "R8 alert follows mask", longint'(alert), longint'(aen));
    held = rms_out;
    for (int k = 0; k < 6; k++) cyc(1'b1, ch, gen(0), 1'b0);
    check(done == 1'b1 && rms_out == held, "R6 result held", longint'(rms_out), longint'(held));
    alert_en = ~aen;
    cyc(1'b0, ch, '0, 1'b0);
    check(alert == ~aen, "R8 alert after mask change", longint'(alert), longint'(~aen));
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    check(rms_out == '0 && done == 1'b0 && alert == 1'b0, "R1 reset state", longint'(rms_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: samples before any start are ignored
    cfg_chan = 3'd1; alert_en = 1'b1;
    for (int k = 0; k < 300; k++) cyc(1'b1, 3'd1, 16'hFFFF, 1'b0);
    check(done == 1'b0 && rms_out == '0, "R10 no effect before start", longint'(rms_out), 0);
    // directed corners
    measure(3, 3'd2, 1'b0, 1'b1, 1, 1'b1, 65535);
    measure(1, 3'd5, 1'b1, 1'b0, 2, 1'b0, 32768);
    measure(0, 3'd7, 1'b1, 1'b1, 3, 1'b1, 0);
    measure(2, 3'd0, 1'b0, 1'b0, 2, 1'b0, 0);
    // R7: restart mid-block discards the partial full-scale samples
    cfg_chan = 3'd4; cfg_len_code = 2'd1; cfg_dc_sub = 1'b0;
    cyc(1'b1, 3'd4, 16'hFFFF, 1'b1);
    for (int k = 0; k < 9; k++) cyc(1'b1, 3'd4, 16'hFFFF, 1'b0);
    measure(1, 3'd4, 1'b0, 1'b1, 2, 1'b1, 0);
    // random runs
    for (int r = 0; r < 12; r++) begin
      measure($urandom_range(0, 3), CW'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), (r % 2 == 0) ? 0 : 4, 1'($urandom_range(0, 1)), -1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule